// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. A controller pulses the start strobe together with a starting column, a length code, an ordering bit, a read/write flag and a single-write option. From the next clock onward the block puts out one column per cycle, with a valid flag and a flag that marks the final beat.

Fixed-length bursts stay inside an aligned block whose size equals the burst length. The upper column bits are held, and only the low bits step in either sequential or interleaved (XOR) order. A full-page mode steps through the whole row, wraps at its end, and runs until a terminate strobe arrives. A length code the block cannot use is flagged as an error and degrades to a single access.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `cfg_err_o` are low until a start strobe is accepted.
- R2: A start strobe sampled on a clock edge makes beat 0 appear on the outputs after that edge, with one further beat per cycle. Length code 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. `last_o` is high only on the final beat, and `valid_o` falls in the cycle after it.
- R3: With `ilv_i`=0, beat k of an N-beat fixed burst (N=2,4,8) is `(col & ~(N-1)) | ((col + k) mod N)`. The address wraps inside the aligned block and never leaves it.
- R4: With `ilv_i`=1, beat k of an N-beat fixed burst is `(col & ~(N-1)) | ((col mod N) XOR k)`. For example, start 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R5: With length code 0, the single beat is the given column whatever the value of `ilv_i`.
- R6: Length code 7 with `ilv_i`=0 is a full-page burst. Beat k is `(col + k) mod 2^COL_W` (512 locations by default), `last_o` never rises, and the burst runs until terminated.
- R7: When `is_write_i`=1 and `wbm_single_i`=1, the burst is one beat with `last_o` high, whatever the length code. A read with `wbm_single_i`=1 still uses the programmed length.
- R8: Length codes 4, 5 and 6, and code 7 together with `ilv_i`=1, produce a single beat at the given column, with `cfg_err_o` and `last_o` high.
- R9: A start strobe during an active burst aborts it. Beat 0 of the new burst appears in the next cycle.
- R10: `term_i` sampled high during a burst, without a start strobe, makes `valid_o` low in the next cycle. When start and terminate are sampled together, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst with the current settings |
| is_write_i | input | 1 | 1 = write burst, 0 = read burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 0 = sequential order, 1 = interleaved order |
| wbm_single_i | input | 1 | Writes use a single location |
| col_start_i | input | COL_W | Starting column |
| term_i | input | 1 | Stop the running burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is present |
| last_o | output | 1 | Final beat of a fixed-length burst |
| cfg_err_o | output | 1 | Current access comes from an unusable length setting |

## Verification
The ordering is swept over every length code 0 to 3, both order types and all eight low starting offsets, each at three block positions including the top of the page. A wrong wrap point, carry into the upper bits or mixed-up sequential/XOR order shows up as a wrong column on a specific beat. A full-page run starting near the page end separates the wrap at 512 from block wrapping. Reserved codes, the write single-location option (in both directions), restart mid-burst, terminate, and start colliding with terminate each get a short directed burst, and the bench checks whether one beat or many appear.

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             is_write_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             wbm_single_i,
  input  logic [COL_W-1:0] col_start_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             cfg_err_o
);
  localparam logic [2:0] FULL_CODE = 3'd7;

  logic             act_q, full_q, ilv_q, err_q;
  logic [COL_W-1:0] start_q, mask_q, k_q;
  logic [COL_W-1:0] mask_d;

  wire single_w = is_write_i & wbm_single_i;
  wire bad_code = (len_code_i[2] & (len_code_i != FULL_CODE)) |
                  ((len_code_i == FULL_CODE) & ilv_i);
  wire full_d   = (len_code_i == FULL_CODE) & ~bad_code & ~single_w;

  always_comb begin
    mask_d = '0;
    if (!(bad_code || single_w)) begin
      case (len_code_i)
        3'd1:    mask_d = COL_W'(1);
        3'd2:    mask_d = COL_W'(3);
        3'd3:    mask_d = COL_W'(7);
        default: mask_d = '0;
      endcase
    end
  end

  wire [COL_W-1:0] seq_w = start_q + k_q;
  wire [COL_W-1:0] lo_w  = ilv_q ? (start_q ^ k_q) : seq_w;

  assign col_o     = full_q ? seq_w : ((start_q & ~mask_q) | (lo_w & mask_q));
  assign valid_o   = act_q;
  assign last_o    = act_q & ~full_q & (k_q == mask_q);
  assign cfg_err_o = act_q & err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
      err_q   <= 1'b0;
      start_q <= '0;
      mask_q  <= '0;
      k_q     <= '0;
    end else if (start_i) begin
      act_q   <= 1'b1;
      full_q  <= full_d;
      ilv_q   <= ilv_i;
      err_q   <= bad_code;
      start_q <= col_start_i;
      mask_q  <= mask_d;
      k_q     <= '0;
    end else if (act_q) begin
      if (term_i || last_o) act_q <= 1'b0;
      else                  k_q   <= k_q + 1'b1;
    end
  end

  assert_start_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);
  assert_end_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);
  assert_last_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
  assert_block_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o) && !$past(start_i) && !full_q) |->
      ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));
  assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> last_o);
  assert_term_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && term_i && !start_i) |=> !valid_o);
endmodule

// File: tb/test_sdram_col_seq.sv
module test_sdram_col_seq;
  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0, is_write_i = 1'b0, ilv_i = 1'b0;
  logic             wbm_single_i = 1'b0, term_i = 1'b0;
  logic [2:0]       len_code_i = '0;
  logic [COL_W-1:0] col_start_i = '0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, cfg_err_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  sdram_col_seq #(.COL_W(COL_W)) i_sdram_col_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_write_i(is_write_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .wbm_single_i(wbm_single_i),
    .col_start_i(col_start_i), .term_i(term_i), .col_o(col_o),
    .valid_o(valid_o), .last_o(last_o), .cfg_err_o(cfg_err_o));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int code, input int ilv, input int col, input int k);
    int n, base, lo;
    if (code == 7) return (col + k) % PAGE;
    n    = 1 << code;
    base = col & ~(n - 1);
    lo   = col & (n - 1);
    return base | (ilv ? (lo ^ k) : ((lo + k) % n));
  endfunction

  // called at a negedge; leaves the next negedge with beat 0 on the outputs
  task automatic fire(input int code, input int ilv, input int wr, input int wbm,
                      input int col, input int trm);
    start_i = 1'b1; len_code_i = 3'(code); ilv_i = ilv[0]; is_write_i = wr[0];
    wbm_single_i = wbm[0]; col_start_i = COL_W'(col); term_i = trm[0];
    @(negedge clk);
    start_i = 1'b0; term_i = 1'b0;
  endtask

  task automatic expect_beats(input string req, input int code, input int ilv,
                              input int col, input int n, input int err);
    for (int k = 0; k < n; k++) begin
      chk({req, " valid"}, int'(valid_o), 1);
      chk({req, " col"}, int'(col_o), exp_col(code, ilv, col, k));
      chk({req, " last"}, int'(last_o), (k == n - 1) ? 1 : 0);
      chk({req, " err"}, int'(cfg_err_o), err);
      @(negedge clk);
    end
    chk({req, " end"}, int'(valid_o), 0);
  endtask

  initial begin
    #(5ns * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int bases[3] = '{0, 'h1F8, 'hA8};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 last", int'(last_o), 0);
    chk("R1 err", int'(cfg_err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", int'(valid_o), 0);

    // R2 R3 R4 R5 sweep
    for (int code = 0; code < 4; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int b = 0; b < 3; b++)
          for (int lo = 0; lo < 8; lo++) begin
            fire(code, ilv, 0, 0, bases[b] + lo, 0);
            if (code == 0)      expect_beats("R5", code, ilv, bases[b] + lo, 1, 0);
            else if (ilv == 1)  expect_beats("R4", code, ilv, bases[b] + lo, 1 << code, 0);
            else                expect_beats("R3", code, ilv, bases[b] + lo, 1 << code, 0);
          end

    // R4 example 5 -> 5,4,7,6,1,0,3,2
    fire(3, 1, 0, 0, 5, 0);
    expect_beats("R4 example", 3, 1, 5, 8, 0);

    // R6 full page across page end, then terminate
    fire(7, 0, 0, 0, 505, 0);
    for (int k = 0; k < 20; k++) begin
      chk("R6 valid", int'(valid_o), 1);
      chk("R6 col", int'(col_o), exp_col(7, 0, 505, k));
      chk("R6 last", int'(last_o), 0);
      if (k == 19) term_i = 1'b1;
      @(negedge clk);
    end
    term_i = 1'b0;
    chk("R6 R10 term end", int'(valid_o), 0);

    // R7 write single-location option
    fire(3, 0, 1, 1, 'h13, 0);
    expect_beats("R7 write single", 0, 0, 'h13, 1, 0);
    fire(3, 0, 0, 1, 'h13, 0);
    expect_beats("R7 read full length", 3, 0, 'h13, 8, 0);
    fire(2, 1, 1, 0, 'h2E, 0);
    expect_beats("R7 write normal", 2, 1, 'h2E, 4, 0);

    // R8 reserved codes
    for (int c = 4; c < 7; c++) begin
      fire(c, 0, 0, 0, 'h77, 0);
      expect_beats("R8 reserved", 0, 0, 'h77, 1, 1);
    end
    fire(7, 1, 0, 0, 'h101, 0);
    expect_beats("R8 full interleaved", 0, 0, 'h101, 1, 1);

    // R9 restart mid-burst
    fire(3, 0, 0, 0, 'h10, 0);
    chk("R9 first col0", int'(col_o), 'h10);
    @(negedge clk);
    chk("R9 first col1", int'(col_o), 'h11);
    fire(2, 1, 0, 0, 'h22, 0);
    expect_beats("R9 restart", 2, 1, 'h22, 4, 0);

    // R10 terminate fixed burst; start beats terminate
    fire(3, 0, 0, 0, 0, 0);
    chk("R10 beat0", int'(col_o), 0);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    chk("R10 term fixed", int'(valid_o), 0);
    fire(2, 0, 0, 0, 'h45, 1);
    expect_beats("R10 start wins", 2, 0, 'h45, 4, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule